// File: doc/BRIEF.md
# OTP Word Read/Program Sequencer

This block moves whole 32-bit words between a one-time-programmable memory macro and a small word FIFO. Software loads a starting word address and a transfer length stored as "words minus one", then starts an automatic read or an automatic program run. An automatic read fetches two 16-bit halves from the macro for each word, packs them and pushes the result into the FIFO. An automatic program run takes words from the FIFO, or takes a single word from a side input, and issues two 16-bit program requests for each word.

The macro sits behind a fixed-latency 16-bit access. Its read data is sampled in the last cycle of each access. An access lasts one cycle, or two when the slow-rate option is selected at start. While a run is active, the block shows a ready flag, the number of words still to be processed, the live word address and the FIFO occupancy. Software reaches the FIFO through push and pop strobes. It must look at the occupancy before using them. The last word popped by software is held in a shadow register.

Top module: `otpx_top`

## Requirements
- R1: After reset, ready is 1, remaining is 0, the word address is 0, the FIFO level is 0, the shadow word is 0 and mac_req is 0.
- R2: An accepted start (start high while ready) drops ready in the next cycle. Ready returns to 1 in the cycle after the last word completes. mac_req is never high while ready is 1.
- R3: The macro half address is {word address, half}, where half is 0 for the low 16 bits. Within a word, the low half is accessed first. A read run pushes {second half, first half} into the FIFO.
- R4: With slow_sel low at start, every cycle with mac_req high completes one 16-bit access. With slow_sel high, each access holds mac_req and mac_addr for two cycles, and read data is taken in the second cycle.
- R5: The word address increments by one, modulo 2^13, after each completed word. addr_wr loads it only while ready is 1 and start is low.
- R6: At start, remaining becomes the count register plus one (1 for a side-port run). It drops by one per completed word. The run ends when it reaches 0.
- R7: A read run does not begin a new word while the FIFO holds 8 words. It resumes once a word has been popped.
- R8: A program run drives mac_we with mac_req. It writes bits [15:0] and then bits [31:16] of the FIFO head, and pops the head after its second half. It does not begin a word while the FIFO is empty.
- R9: A program run started with side_sel high programs exactly one word, side_word as captured at start. It leaves the FIFO contents and the count register (cnt_value) unchanged. side_sel has no effect on a read run.
- R10: A flush empties the FIFO in one cycle and overrides any push or pop in the same cycle.
- R11: A software push is ignored when the FIFO is full or a read run is active. A software pop is ignored when the FIFO is empty or a program run is active. An accepted pop copies the head into last_rd.
- R12: A start while a run is active is ignored and does not change remaining or the run's direction.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a run (accepted only when ready) |
| op_prog | input | 1 | Run direction at start: 0 read, 1 program |
| side_sel | input | 1 | Program a single word from side_word |
| slow_sel | input | 1 | Two-cycle macro access |
| side_word | input | 32 | Single word for side-port programming |
| cnt_wr | input | 1 | Load the word count register |
| cnt_wdata | input | 13 | Word count minus one |
| addr_wr | input | 1 | Load the macro word address |
| addr_wdata | input | 13 | Starting macro word address |
| flush | input | 1 | Empty the FIFO |
| sw_push | input | 1 | Software push into FIFO |
| sw_wdata | input | 32 | Word for software push |
| sw_pop | input | 1 | Software pop from FIFO |
| mac_rdata | input | 16 | Macro read data |
| mac_req | output | 1 | Macro access request |
| mac_we | output | 1 | Access is a program request |
| mac_addr | output | 14 | Macro half-word address |
| mac_wdata | output | 16 | Macro program data |
| ready | output | 1 | No run in progress |
| remaining | output | 14 | Words still to be processed |
| cur_addr | output | 13 | Current macro word address |
| cnt_value | output | 13 | Word count register |
| fifo_level | output | 4 | Words held in FIFO |
| fifo_head | output | 32 | Word at the FIFO head |
| last_rd | output | 32 | Last word popped by software |

## Verification
On every cycle, the bound checker enforces several invariants: the FIFO level never exceeds its depth, no request is made while ready, the FIFO is empty after a flush, and a read access to a low half never starts with a full FIFO. It also checks that remaining and the word address only hold or step by one during a run, and that a slow access keeps its address for two cycles. The packing order, the values written to the macro, the stall and resume points, the side-port bypass and the ignored start or strobe cases are only shown by the bench. Its reference model predicts each output cycle by cycle across fast and slow reads and programs, FIFO-full and FIFO-empty stalls, and side-port runs.

// File: rtl/otpx_pkg.sv
package otpx_pkg;
    localparam int ADDR_W     = 13;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int FIFO_DEPTH = 8;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int REM_W      = ADDR_W + 1;
    localparam int MAC_AW     = ADDR_W + 1;

    typedef enum logic {S_IDLE, S_RUN} seq_state_e;

    typedef struct packed {
        logic prog;
        logic side;
        logic slow;
    } run_cfg_t;

    function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] lo,
                                                      input logic [HALF_W-1:0] hi);
        return {hi, lo};
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                    input logic upper);
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/otpx_fifo.sv
module otpx_fifo
    import otpx_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int D = FIFO_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     push,
    input  logic [W-1:0]             wdata,
    input  logic                     pop,
    output logic [W-1:0]             head,
    output logic [$clog2(D+1)-1:0]   level
);
    localparam int PW = (D > 1) ? $clog2(D) : 1;
    localparam int LW = $clog2(D + 1);

    logic [W-1:0]  mem [D];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != LW'(D));
    assign do_pop  = pop && (cnt != '0);
    assign head    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(D - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(D - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/otpx_seq.sv
module otpx_seq
    import otpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_prog,
    input  logic                side_sel,
    input  logic                slow_sel,
    input  logic [WORD_W-1:0]   side_word,
    input  logic [ADDR_W-1:0]   cnt_val,
    input  logic                addr_wr,
    input  logic [ADDR_W-1:0]   addr_wdata,
    input  logic [LVL_W-1:0]    fifo_level,
    input  logic [WORD_W-1:0]   fifo_head,
    input  logic [HALF_W-1:0]   mac_rdata,
    output logic                mac_req,
    output logic                mac_we,
    output logic [MAC_AW-1:0]   mac_addr,
    output logic [HALF_W-1:0]   mac_wdata,
    output logic                seq_push,
    output logic [WORD_W-1:0]   seq_wdata,
    output logic                seq_pop,
    output logic                busy,
    output logic                run_read,
    output logic                run_prog,
    output logic                run_slow,
    output logic [REM_W-1:0]    remaining,
    output logic [ADDR_W-1:0]   cur_addr
);
    seq_state_e            state;
    run_cfg_t              cfg;
    logic                  half, ph;
    logic [ADDR_W-1:0]     addr_q;
    logic [REM_W-1:0]      rem_q;
    logic [HALF_W-1:0]     low_q;
    logic [WORD_W-1:0]     side_q;
    logic                  word_start, stall, beat, word_done;
    logic [WORD_W-1:0]     src;

    assign busy       = (state == S_RUN);
    assign run_read   = busy && !cfg.prog;
    assign run_prog   = busy && cfg.prog;
    assign run_slow   = busy && cfg.slow;
    assign word_start = !half && !ph;
    assign stall      = word_start &&
                        (cfg.prog ? (!cfg.side && fifo_level == '0)
                                  : (fifo_level == LVL_W'(FIFO_DEPTH)));
    assign mac_req    = busy && !stall;
    assign mac_we     = mac_req && cfg.prog;
    assign mac_addr   = {addr_q, half};
    assign src        = cfg.side ? side_q : fifo_head;
    assign mac_wdata  = pick_half(src, half);
    assign beat       = mac_req && (!cfg.slow || ph);
    assign word_done  = beat && half;
    assign seq_push   = word_done && !cfg.prog;
    assign seq_wdata  = join_halves(low_q, mac_rdata);
    assign seq_pop    = word_done && cfg.prog && !cfg.side;
    assign remaining  = rem_q;
    assign cur_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cfg    <= '0;
            half   <= 1'b0;
            ph     <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            low_q  <= '0;
            side_q <= '0;
        end else if (state == S_IDLE) begin
            if (start) begin
                state     <= S_RUN;
                cfg.prog  <= op_prog;
                cfg.side  <= op_prog && side_sel;
                cfg.slow  <= slow_sel;
                side_q    <= side_word;
                half      <= 1'b0;
                ph        <= 1'b0;
                rem_q     <= (op_prog && side_sel) ? REM_W'(1)
                                                   : {1'b0, cnt_val} + 1'b1;
            end else if (addr_wr) begin
                addr_q <= addr_wdata;
            end
        end else begin
            if (beat) begin
                ph <= 1'b0;
                if (!half) begin
                    half  <= 1'b1;
                    low_q <= mac_rdata;
                end else begin
                    half   <= 1'b0;
                    addr_q <= addr_q + 1'b1;
                    rem_q  <= rem_q - 1'b1;
                    if (rem_q == REM_W'(1)) state <= S_IDLE;
                end
            end else if (mac_req && cfg.slow) begin
                ph <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/otpx_top.sv
module otpx_top
    import otpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_prog,
    input  logic                side_sel,
    input  logic                slow_sel,
    input  logic [WORD_W-1:0]   side_word,
    input  logic                cnt_wr,
    input  logic [ADDR_W-1:0]   cnt_wdata,
    input  logic                addr_wr,
    input  logic [ADDR_W-1:0]   addr_wdata,
    input  logic                flush,
    input  logic                sw_push,
    input  logic [WORD_W-1:0]   sw_wdata,
    input  logic                sw_pop,
    input  logic [HALF_W-1:0]   mac_rdata,
    output logic                mac_req,
    output logic                mac_we,
    output logic [MAC_AW-1:0]   mac_addr,
    output logic [HALF_W-1:0]   mac_wdata,
    output logic                ready,
    output logic [REM_W-1:0]    remaining,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [ADDR_W-1:0]   cnt_value,
    output logic [LVL_W-1:0]    fifo_level,
    output logic [WORD_W-1:0]   fifo_head,
    output logic [WORD_W-1:0]   last_rd
);
    logic [ADDR_W-1:0] cnt_q;
    logic [WORD_W-1:0] last_q;
    logic              seq_push, seq_pop, busy, run_read, run_prog, run_slow;
    logic [WORD_W-1:0] seq_wdata;
    logic              sw_push_ok, sw_pop_ok, f_push, f_pop;
    logic [WORD_W-1:0] f_wdata;

    assign sw_push_ok = sw_push && !run_read;
    assign sw_pop_ok  = sw_pop && !run_prog && (fifo_level != '0);
    assign f_push     = seq_push || sw_push_ok;
    assign f_wdata    = seq_push ? seq_wdata : sw_wdata;
    assign f_pop      = seq_pop || sw_pop_ok;
    assign ready      = !busy;
    assign cnt_value  = cnt_q;
    assign last_rd    = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            if (cnt_wr)    cnt_q  <= cnt_wdata;
            if (sw_pop_ok) last_q <= fifo_head;
        end
    end

    otpx_fifo #(.W(WORD_W), .D(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .head  (fifo_head),
        .level (fifo_level)
    );

    otpx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_prog    (op_prog),
        .side_sel   (side_sel),
        .slow_sel   (slow_sel),
        .side_word  (side_word),
        .cnt_val    (cnt_q),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .fifo_level (fifo_level),
        .fifo_head  (fifo_head),
        .mac_rdata  (mac_rdata),
        .mac_req    (mac_req),
        .mac_we     (mac_we),
        .mac_addr   (mac_addr),
        .mac_wdata  (mac_wdata),
        .seq_push   (seq_push),
        .seq_wdata  (seq_wdata),
        .seq_pop    (seq_pop),
        .busy       (busy),
        .run_read   (run_read),
        .run_prog   (run_prog),
        .run_slow   (run_slow),
        .remaining  (remaining),
        .cur_addr   (cur_addr)
    );
endmodule

// File: rtl/otpx_chk.sv
module otpx_chk
    import otpx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ready,
    input logic                mac_req,
    input logic                mac_we,
    input logic [MAC_AW-1:0]   mac_addr,
    input logic [LVL_W-1:0]    fifo_level,
    input logic [REM_W-1:0]    remaining,
    input logic [ADDR_W-1:0]   cur_addr,
    input logic                flush,
    input logic                run_slow
);
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(FIFO_DEPTH));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mac_req);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fifo_level == '0));

    a_r7_read_room: assert property (@(posedge clk) disable iff (rst)
        (mac_req && !mac_we && !mac_addr[0]) |-> (fifo_level != LVL_W'(FIFO_DEPTH)));

    a_r6_rem_step: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (remaining == $past(remaining) ||
                    remaining == $past(remaining) - 1'b1));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (cur_addr == $past(cur_addr) ||
                    cur_addr == $past(cur_addr) + 1'b1));

    a_r4_slow_pair: assert property (@(posedge clk) disable iff (rst)
        (run_slow && $rose(mac_req)) |=> (mac_req && $stable(mac_addr)));
endmodule

bind otpx_top otpx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .mac_req    (mac_req),
    .mac_we     (mac_we),
    .mac_addr   (mac_addr),
    .fifo_level (fifo_level),
    .remaining  (remaining),
    .cur_addr   (cur_addr),
    .flush      (flush),
    .run_slow   (run_slow)
);

// File: tb/sim_otpx_top.sv
module sim_otpx_top;
    import otpx_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, start, op_prog, side_sel, slow_sel, cnt_wr, addr_wr, flush, sw_push, sw_pop;
    logic [31:0] side_word, sw_wdata;
    logic [12:0] cnt_wdata, addr_wdata;
    logic [15:0] mac_rdata;
    logic mac_req, mac_we, ready;
    logic [13:0] mac_addr, remaining;
    logic [15:0] mac_wdata;
    logic [12:0] cur_addr, cnt_value;
    logic [3:0]  fifo_level;
    logic [31:0] fifo_head, last_rd;

    otpx_top u0 (
        .clk(clk), .rst(rst), .start(start), .op_prog(op_prog), .side_sel(side_sel),
        .slow_sel(slow_sel), .side_word(side_word), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .flush(flush), .sw_push(sw_push),
        .sw_wdata(sw_wdata), .sw_pop(sw_pop), .mac_rdata(mac_rdata), .mac_req(mac_req),
        .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata), .ready(ready),
        .remaining(remaining), .cur_addr(cur_addr), .cnt_value(cnt_value),
        .fifo_level(fifo_level), .fifo_head(fifo_head), .last_rd(last_rd)
    );

    function automatic logic [15:0] fmac(input logic [13:0] a);
        return {a[7:0] ^ 8'h3C, a[13:6] + 8'd17};
    endfunction
    assign mac_rdata = fmac(mac_addr);

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit checking = 0, done = 0;

    // reference model state
    bit m_busy, m_prog, m_side, m_slow, m_half, m_ph;
    logic [12:0] m_addr, m_cnt;
    int m_rem;
    logic [31:0] m_sw, m_last, m_pw;
    logic [15:0] m_low;
    logic [31:0] q[$];
    bit t_req, t_beat, t_spush, t_spop, t_swpu, t_swpo, t_was;

    function automatic bit m_req();
        if (!m_busy) return 1'b0;
        if (!m_half && !m_ph) begin
            if (!m_prog && q.size() == 8) return 1'b0;
            if (m_prog && !m_side && q.size() == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_prog = 0; m_side = 0; m_slow = 0; m_half = 0; m_ph = 0;
            m_addr = '0; m_cnt = '0; m_rem = 0; m_sw = '0; m_last = '0; m_low = '0;
            q.delete();
        end else begin
            t_was   = m_busy;
            t_req   = m_req();
            t_beat  = t_req && (!m_slow || m_ph);
            t_spush = 0; t_spop = 0;
            t_swpu  = sw_push && !(m_busy && !m_prog) && q.size() < 8;
            t_swpo  = sw_pop && !(m_busy && m_prog) && q.size() > 0;
            if (t_beat) begin
                m_ph = 0;
                if (!m_half) begin
                    m_low  = fmac({m_addr, 1'b0});
                    m_half = 1;
                end else begin
                    if (!m_prog) begin
                        t_spush = 1;
                        m_pw = {fmac({m_addr, 1'b1}), m_low};
                    end else if (!m_side) t_spop = 1;
                    m_half = 0;
                    m_addr = m_addr + 13'd1;
                    m_rem  = m_rem - 1;
                    if (m_rem == 0) m_busy = 0;
                end
            end else if (t_req && m_slow) m_ph = 1;
            if (t_swpo) m_last = q[0];
            if (flush) q.delete();
            else begin
                if (t_spop || t_swpo) void'(q.pop_front());
                if (t_spush) q.push_back(m_pw);
                if (t_swpu) q.push_back(sw_wdata);
            end
            if (!t_was && start) begin
                m_busy = 1; m_prog = op_prog; m_side = op_prog && side_sel;
                m_slow = slow_sel; m_sw = side_word; m_half = 0; m_ph = 0;
                m_rem  = m_side ? 1 : int'(m_cnt) + 1;
            end else if (!t_was && addr_wr) m_addr = addr_wdata;
            if (cnt_wr) m_cnt = cnt_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && checking && !done) begin
            logic [31:0] src;
            bit er;
            er = m_req();
            chk("R2", {31'd0, ready}, {31'd0, !m_busy});
            chk("R6", {18'd0, remaining}, m_rem);
            chk("R5", {19'd0, cur_addr}, {19'd0, m_addr});
            chk("R9", {19'd0, cnt_value}, {19'd0, m_cnt});
            chk("R11", {28'd0, fifo_level}, q.size());
            chk("R11", last_rd, m_last);
            if (q.size() > 0) chk("R3", fifo_head, q[0]);
            chk(m_slow ? "R4" : (m_busy && !er ? "R7" : "R8"), {31'd0, mac_req}, {31'd0, er});
            if (er) begin
                chk("R3", {18'd0, mac_addr}, {18'd0, m_addr, m_half});
                chk("R8", {31'd0, mac_we}, {31'd0, m_prog});
                if (m_prog) begin
                    src = m_side ? m_sw : (q.size() > 0 ? q[0] : 32'd0);
                    chk(m_side ? "R9" : "R8", {16'd0, mac_wdata},
                        {16'd0, m_half ? src[31:16] : src[15:0]});
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_in();
        start = 0; cnt_wr = 0; addr_wr = 0; flush = 0; sw_push = 0; sw_pop = 0;
    endtask

    task automatic do_push(input logic [31:0] v);
        @(negedge clk); sw_push = 1; sw_wdata = v;
        @(negedge clk); sw_push = 0;
    endtask

    task automatic do_pop();
        @(negedge clk); sw_pop = 1;
        @(negedge clk); sw_pop = 0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        chk("R10", {28'd0, fifo_level}, 32'd0);
    endtask

    task automatic setup(input logic [12:0] a, input logic [12:0] c);
        @(negedge clk); addr_wr = 1; addr_wdata = a; cnt_wr = 1; cnt_wdata = c;
        @(negedge clk); addr_wr = 0; cnt_wr = 0;
    endtask

    task automatic go(input bit prog, input bit side, input bit slow, input logic [31:0] sw);
        @(negedge clk); start = 1; op_prog = prog; side_sel = side; slow_sel = slow; side_word = sw;
        @(negedge clk); start = 0; side_sel = 0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
        step(1);
    endtask

    initial begin
        rst = 1; clear_in(); op_prog = 0; side_sel = 0; slow_sel = 0;
        side_word = '0; sw_wdata = '0; cnt_wdata = '0; addr_wdata = '0;
        step(3);
        rst = 0;
        step(1);
        chk("R1", {31'd0, ready}, 32'd1);
        chk("R1", {18'd0, remaining}, 32'd0);
        chk("R1", {28'd0, fifo_level}, 32'd0);
        chk("R1", {19'd0, cur_addr}, 32'd0);
        chk("R1", last_rd, 32'd0);
        chk("R1", {31'd0, mac_req}, 32'd0);
        checking = 1;

        // fast read of 3 words, with an ignored start while busy (R12)
        setup(13'd5, 13'd2);
        go(0, 0, 0, 32'h0);
        @(negedge clk); start = 1; op_prog = 1;
        @(negedge clk); start = 0; op_prog = 0;
        chk("R12", {31'd0, mac_we}, 32'd0);
        chk("R12", {18'd0, remaining}, m_rem);
        wait_ready();
        repeat (4) do_pop();

        // slow read of 10 words, stalls on full FIFO (R7), resumes after pops
        setup(13'h1FFC, 13'd9);
        go(0, 1, 1, 32'hDEAD_BEEF);
        step(60);
        chk("R7", {28'd0, fifo_level}, 32'd8);
        do_pop(); step(6); do_pop(); step(6); do_pop();
        wait_ready();
        while (fifo_level != 0) do_pop();
        do_pop();

        // software push into full FIFO is dropped, then flush
        for (int i = 0; i < 9; i++) do_push(32'hA000_0000 + i);
        chk("R11", {28'd0, fifo_level}, 32'd8);
        do_flush();

        // fast program of 6 words, stalls empty after 4 (R8)
        for (int i = 0; i < 4; i++) do_push(32'h1234_0000 + 32'h0101_0101 * i);
        setup(13'd40, 13'd5);
        go(1, 0, 0, 32'h0);
        step(25);
        chk("R8", {18'd0, remaining}, 32'd2);
        do_pop();
        do_push(32'hCAFE_F00D); do_push(32'h5555_AAAA);
        wait_ready();

        // side-port programming, slow: one word, FIFO and count untouched (R9)
        for (int i = 0; i < 3; i++) do_push(32'h7700_0000 + i);
        setup(13'd100, 13'd7);
        go(1, 1, 1, 32'h89AB_CDEF);
        wait_ready();
        chk("R9", {28'd0, fifo_level}, 32'd3);
        chk("R9", {19'd0, cnt_value}, 32'd7);
        chk("R9", {19'd0, cur_addr}, 32'd101);

        // side-port program, fast
        go(1, 1, 0, 32'h0F0F_1234);
        wait_ready();

        // program drains the 3 words slowly
        setup(13'd200, 13'd2);
        go(1, 0, 1, 32'h0);
        wait_ready();

        // read with side_sel set behaves as normal read (R9), then flush
        setup(13'd300, 13'd1);
        go(0, 1, 0, 32'hFFFF_FFFF);
        wait_ready();
        chk("R9", {28'd0, fifo_level}, 32'd2);
        do_flush();
        step(3);
        finish_run();
    end
endmodule